// File: doc/BRIEF.md
# Processor power state controller

This block steps a platform between processor idle states and system sleep states. It drives a stop-clock request to the processor, a CPU sleep request, a set of gated clock enables and a real-time clock enable. Software selects a target state by writing a code. The processor's halt indication moves the block into the auto-halt state. A wake event brings the block back from a sleep state.

In the full-on state the stop-clock request can be pulsed over a fixed 16-cycle window to lower processor throughput. Software starts this with an enable and a duty value. A thermal alarm forces the same throttling even when software has left it off. Entry into a sleep state is a timed sequence of steps, each a programmable delay apart. A wake from the shallow sleep states runs that sequence backwards. A wake from the deep states is a single restart step.

Top module: `cpu_pwr_seq`

## Requirements
- R1: After reset, curState is 0 (full on), stopClkReq, cpuSleepReq, memRetained and busy are low, every clkEn bit is high, and rtcClkEn is high.
- R2: curState encodes C0=0, C1=1, C2=2, S1=3, S3=4, S4=5, S5=6. In C0, C1 or C2, a write (tgtWrEn high for one cycle) of 0 or 2 takes effect in curState at the next clock edge. Writes of 1 or 7 are ignored.
- R3: In C0, with swThrEn high, stopClkReq is high on exactly 2*swDuty of any 16 consecutive cycles. A duty value of 0 gives no throttling.
- R4: While thermAlarm is high, C0 is throttled with thermDuty even when swThrEn is low. When both sources are active, the larger duty applies.
- R5: In C0, a high haltInd moves the block to C1 at the next edge. In C1, stopClkReq stays low even when throttling is configured. When haltInd drops, the block returns to C0.
- R6: In C2, stopClkReq is high on every cycle. A write of 0 leaves C2 and releases the request.
- R7: With D = max(stepDelay, 2), a write of a sleep code (3 to 6) sets curState to that code and raises stopClkReq at the write edge. The CPU sleep step follows D edges later, and the clock gating step 2*D edges later.
- R8: cpuSleepReq rises only on entry to S1, and only when sleepCpuEn is high.
- R9: Once the gating step completes, S3, S4 and S5 have every clkEn bit low while rtcClkEn stays high. memRetained is high in S3 only.
- R10: A wake event in S1 or S3 reverses the entry order. Clocks are re-enabled and memRetained cleared at the wake edge. cpuSleepReq drops D edges later. stopClkReq drops and curState returns to 0 at 2*D edges.
- R11: A wake event in S4 or S5 restores the reset output levels and curState 0 at the wake edge.
- R12: busy is high for the 2*D cycles of an entry or exit sequence. Target writes are ignored while busy and in any settled sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tgtWrEn | input | 1 | Target-state write strobe |
| tgtState | input | 3 | Target-state code |
| haltInd | input | 1 | Processor halt indication |
| wakeEvt | input | 1 | Wake event |
| sleepCpuEn | input | 1 | Allow CPU sleep request in S1 |
| stepDelay | input | DLY_W | Cycles between sequence steps (minimum 2 applied) |
| swThrEn | input | 1 | Software throttle enable |
| swDuty | input | DUTY_W | Software throttle duty in eighths |
| thermAlarm | input | 1 | Thermal alarm |
| thermDuty | input | DUTY_W | Thermal throttle duty in eighths |
| stopClkReq | output | 1 | Stop-clock request to processor |
| cpuSleepReq | output | 1 | CPU sleep request |
| clkEn | output | NUM_CLK | Gated clock enables |
| rtcClkEn | output | 1 | Real-time clock enable |
| memRetained | output | 1 | Memory contents retained (S3) |
| busy | output | 1 | Transition in progress |
| curState | output | 3 | Current state code |

## Verification
The throttle is swept over every pairing of the software enable, the thermal alarm and both 3-bit duty values. Each pairing is counted over a 16-cycle window. This separates "software only", "thermal forcing" and "larger of the two" from one another, and catches any off-by-one in the pulse width. Each sleep code is entered under several step delays, including the clamped values 0 and 2, with the CPU-sleep option both on and off. This tells apart the step order, the step spacing and the per-state output levels. The S1/S3 wakes are compared against the S4/S5 wakes to show reversed sequencing versus an immediate restart. A write issued mid-sequence, and another issued while settled in a sleep state, show that writes are ignored while busy and in sleep states.

// File: rtl/cpu_pwr_pkg.sv
package cpu_pwr_pkg;

  typedef enum logic [2:0] {
    PS_C0 = 3'd0,
    PS_C1 = 3'd1,
    PS_C2 = 3'd2,
    PS_S1 = 3'd3,
    PS_S3 = 3'd4,
    PS_S4 = 3'd5,
    PS_S5 = 3'd6
  } pwr_state_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ENTER = 2'd1,
    SEQ_LEAVE = 2'd2
  } seq_mode_e;

  typedef struct packed {
    logic setStop;
    logic clrStop;
    logic setSleep;
    logic clrSleep;
    logic gateClk;
    logic ungateClk;
    logic keepMem;
    logic restart;
    logic thrAllow;
  } pwr_strobe_t;

endpackage

// File: rtl/cpu_pwr_ctrl.sv
module cpu_pwr_ctrl
  import cpu_pwr_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tgtWrEn,
  input  logic [2:0]       tgtState,
  input  logic             haltInd,
  input  logic             wakeEvt,
  input  logic             sleepCpuEn,
  input  logic [DLY_W-1:0] stepDelay,
  output pwr_strobe_t      stb,
  output pwr_state_e       curState,
  output logic             busy
);

  localparam logic [DLY_W-1:0] MIN_DLY = DLY_W'(2);

  pwr_state_e stateQ, stateD;
  seq_mode_e  modeQ, modeD;
  logic       stepQ, stepD;
  logic [DLY_W-1:0] dlyQ, dlyD;
  logic [DLY_W-1:0] effDly, dlyLoad;
  logic sleepTgt, awake;

  assign effDly   = (stepDelay < MIN_DLY) ? MIN_DLY : stepDelay;
  assign dlyLoad  = effDly - DLY_W'(1);
  assign sleepTgt = (tgtState >= 3'd3) && (tgtState <= 3'd6);
  assign awake    = (stateQ == PS_C0) || (stateQ == PS_C1) || (stateQ == PS_C2);

  always_comb begin
    stateD = stateQ;
    modeD  = modeQ;
    stepD  = stepQ;
    dlyD   = dlyQ;
    stb    = '0;
    stb.thrAllow = (stateQ == PS_C0);
    case (modeQ)
      SEQ_IDLE: begin
        if (awake) begin
          if (tgtWrEn && sleepTgt) begin
            stateD = pwr_state_e'(tgtState);
            modeD  = SEQ_ENTER;
            stepD  = 1'b0;
            dlyD   = dlyLoad;
            stb.setStop = 1'b1;
          end else if (tgtWrEn && (tgtState == 3'd2)) begin
            stateD = PS_C2;
            stb.setStop = 1'b1;
          end else if (tgtWrEn && (tgtState == 3'd0)) begin
            stateD = PS_C0;
            stb.clrStop = 1'b1;
          end else if ((stateQ == PS_C0) && haltInd) begin
            stateD = PS_C1;
          end else if ((stateQ == PS_C1) && !haltInd) begin
            stateD = PS_C0;
          end
        end else if (wakeEvt) begin
          if ((stateQ == PS_S1) || (stateQ == PS_S3)) begin
            modeD = SEQ_LEAVE;
            stepD = 1'b0;
            dlyD  = dlyLoad;
            stb.ungateClk = 1'b1;
          end else begin
            stateD = PS_C0;
            stb.restart = 1'b1;
          end
        end
      end
      SEQ_ENTER: begin
        if (dlyQ != '0) begin
          dlyD = dlyQ - DLY_W'(1);
        end else if (!stepQ) begin
          stb.setSleep = (stateQ == PS_S1) && sleepCpuEn;
          stepD = 1'b1;
          dlyD  = dlyLoad;
        end else begin
          stb.gateClk = (stateQ == PS_S3) || (stateQ == PS_S4) || (stateQ == PS_S5);
          stb.keepMem = (stateQ == PS_S3);
          modeD = SEQ_IDLE;
        end
      end
      SEQ_LEAVE: begin
        if (dlyQ != '0) begin
          dlyD = dlyQ - DLY_W'(1);
        end else if (!stepQ) begin
          stb.clrSleep = 1'b1;
          stepD = 1'b1;
          dlyD  = dlyLoad;
        end else begin
          stb.clrStop = 1'b1;
          stateD = PS_C0;
          modeD  = SEQ_IDLE;
        end
      end
      default: modeD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PS_C0;
      modeQ  <= SEQ_IDLE;
      stepQ  <= 1'b0;
      dlyQ   <= '0;
    end else begin
      stateQ <= stateD;
      modeQ  <= modeD;
      stepQ  <= stepD;
      dlyQ   <= dlyD;
    end
  end

  assign curState = stateQ;
  assign busy     = (modeQ != SEQ_IDLE);

endmodule

// File: rtl/cpu_pwr_dp.sv
module cpu_pwr_dp
  import cpu_pwr_pkg::*;
#(
  parameter int NUM_CLK = 4,
  parameter int DUTY_W  = 3,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  pwr_strobe_t        stb,
  input  logic               swThrEn,
  input  logic [DUTY_W-1:0]  swDuty,
  input  logic               thermAlarm,
  input  logic [DUTY_W-1:0]  thermDuty,
  output logic               stopClkReq,
  output logic               cpuSleepReq,
  output logic [NUM_CLK-1:0] clkEn,
  output logic               rtcClkEn,
  output logic               memRetained
);

  localparam int DUTY_STEPS = 2 ** DUTY_W;
  localparam int SCALE      = (2 ** PHASE_W) / DUTY_STEPS;
  localparam logic [PHASE_W:0] SCALE_V = (PHASE_W+1)'(SCALE);

  logic [PHASE_W-1:0] phaseQ;
  logic [DUTY_W-1:0]  swEff, thEff, duty;
  logic [PHASE_W:0]   thrLimit;
  logic thrPulse;
  logic holdQ, sleepQ, gatedQ, memQ;

  assign swEff    = swThrEn ? swDuty : '0;
  assign thEff    = thermAlarm ? thermDuty : '0;
  assign duty     = (thEff > swEff) ? thEff : swEff;
  assign thrLimit = (PHASE_W+1)'(duty) * SCALE_V;
  assign thrPulse = ({1'b0, phaseQ} < thrLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= '0;
    else       phaseQ <= phaseQ + PHASE_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ  <= 1'b0;
      sleepQ <= 1'b0;
      gatedQ <= 1'b0;
      memQ   <= 1'b0;
    end else if (stb.restart) begin
      holdQ  <= 1'b0;
      sleepQ <= 1'b0;
      gatedQ <= 1'b0;
      memQ   <= 1'b0;
    end else begin
      if (stb.setStop)        holdQ <= 1'b1;
      else if (stb.clrStop)   holdQ <= 1'b0;
      if (stb.setSleep)       sleepQ <= 1'b1;
      else if (stb.clrSleep)  sleepQ <= 1'b0;
      if (stb.gateClk) begin
        gatedQ <= 1'b1;
        memQ   <= stb.keepMem;
      end else if (stb.ungateClk) begin
        gatedQ <= 1'b0;
        memQ   <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_clk
    assign clkEn[g] = ~gatedQ;
  end

  assign stopClkReq  = holdQ | (stb.thrAllow & thrPulse);
  assign cpuSleepReq = sleepQ;
  assign rtcClkEn    = 1'b1;
  assign memRetained = memQ;

endmodule

// File: rtl/cpu_pwr_seq.sv
module cpu_pwr_seq
  import cpu_pwr_pkg::*;
#(
  parameter int NUM_CLK = 4,
  parameter int DLY_W   = 4,
  parameter int DUTY_W  = 3,
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tgtWrEn,
  input  logic [2:0]         tgtState,
  input  logic               haltInd,
  input  logic               wakeEvt,
  input  logic               sleepCpuEn,
  input  logic [DLY_W-1:0]   stepDelay,
  input  logic               swThrEn,
  input  logic [DUTY_W-1:0]  swDuty,
  input  logic               thermAlarm,
  input  logic [DUTY_W-1:0]  thermDuty,
  output logic               stopClkReq,
  output logic               cpuSleepReq,
  output logic [NUM_CLK-1:0] clkEn,
  output logic               rtcClkEn,
  output logic               memRetained,
  output logic               busy,
  output logic [2:0]         curState
);

  pwr_strobe_t stb;
  pwr_state_e  stateE;

  cpu_pwr_ctrl #(.DLY_W(DLY_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tgtWrEn(tgtWrEn), .tgtState(tgtState),
    .haltInd(haltInd), .wakeEvt(wakeEvt), .sleepCpuEn(sleepCpuEn),
    .stepDelay(stepDelay), .stb(stb), .curState(stateE), .busy(busy)
  );

  cpu_pwr_dp #(.NUM_CLK(NUM_CLK), .DUTY_W(DUTY_W), .PHASE_W(PHASE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .swThrEn(swThrEn), .swDuty(swDuty),
    .thermAlarm(thermAlarm), .thermDuty(thermDuty), .stopClkReq(stopClkReq),
    .cpuSleepReq(cpuSleepReq), .clkEn(clkEn), .rtcClkEn(rtcClkEn),
    .memRetained(memRetained)
  );

  assign curState = stateE;

endmodule

// File: rtl/cpu_pwr_seq_chk.sv
module cpu_pwr_seq_chk #(
  parameter int NUM_CLK = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         curState,
  input logic               stopClkReq,
  input logic               cpuSleepReq,
  input logic [NUM_CLK-1:0] clkEn,
  input logic               memRetained,
  input logic               busy
);

  assert_c1_no_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 3'd1) |-> !stopClkReq);

  assert_c2_holds_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curState == 3'd2) |-> stopClkReq);

  assert_sleep_after_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuSleepReq) |-> stopClkReq);

  assert_gate_after_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkEn[0]) |-> stopClkReq);

  assert_sleep_only_s1_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuSleepReq |-> (curState == 3'd3));

  assert_mem_only_s3_R9: assert property (@(posedge clk) disable iff (!rstN)
    memRetained |-> ((curState == 3'd4) && (clkEn == '0)));

  assert_busy_in_sleep_R12: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ((curState >= 3'd3) && (curState <= 3'd6)));

endmodule

bind cpu_pwr_seq cpu_pwr_seq_chk #(.NUM_CLK(NUM_CLK)) chk_i (
  .clk(clk), .rstN(rstN), .curState(curState), .stopClkReq(stopClkReq),
  .cpuSleepReq(cpuSleepReq), .clkEn(clkEn), .memRetained(memRetained),
  .busy(busy)
);

// File: tb/cpu_pwr_seq_tb_top.sv
module cpu_pwr_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CLK = 4;
  localparam int ALL_ON  = (1 << NUM_CLK) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tgtWrEn = 1'b0;
  logic [2:0] tgtState = 3'd0;
  logic haltInd = 1'b0, wakeEvt = 1'b0, sleepCpuEn = 1'b0;
  logic [3:0] stepDelay = 4'd2;
  logic swThrEn = 1'b0, thermAlarm = 1'b0;
  logic [2:0] swDuty = 3'd0, thermDuty = 3'd0;
  logic stopClkReq, cpuSleepReq, rtcClkEn, memRetained, busy;
  logic [NUM_CLK-1:0] clkEn;
  logic [2:0] curState;

  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_pwr_seq #(.NUM_CLK(NUM_CLK)) dut_i (
    .clk(clk), .rstN(rstN), .tgtWrEn(tgtWrEn), .tgtState(tgtState),
    .haltInd(haltInd), .wakeEvt(wakeEvt), .sleepCpuEn(sleepCpuEn),
    .stepDelay(stepDelay), .swThrEn(swThrEn), .swDuty(swDuty),
    .thermAlarm(thermAlarm), .thermDuty(thermDuty), .stopClkReq(stopClkReq),
    .cpuSleepReq(cpuSleepReq), .clkEn(clkEn), .rtcClkEn(rtcClkEn),
    .memRetained(memRetained), .busy(busy), .curState(curState)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doWrite(input int v);
    tgtState = 3'(v);
    tgtWrEn  = 1'b1;
    @(negedge clk);
    tgtWrEn  = 1'b0;
  endtask

  task automatic countStop(output int cnt);
    cnt = 0;
    repeat (16) begin
      @(negedge clk);
      cnt += int'(stopClkReq);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset levels
    chk("R1 state", int'(curState), 0);
    chk("R1 stop", int'(stopClkReq), 0);
    chk("R1 sleep", int'(cpuSleepReq), 0);
    chk("R1 clkEn", int'(clkEn), ALL_ON);
    chk("R1 rtc", int'(rtcClkEn), 1);
    chk("R1 mem", int'(memRetained), 0);
    chk("R1 busy", int'(busy), 0);

    // R3 / R4 throttle sweep
    for (int sw = 0; sw < 2; sw++)
      for (int th = 0; th < 2; th++)
        for (int sd = 0; sd < 8; sd++)
          for (int td = 0; td < 8; td++) begin
            int eff;
            swThrEn = sw[0]; thermAlarm = th[0];
            swDuty = 3'(sd); thermDuty = 3'(td);
            eff = (sw != 0) ? sd : 0;
            if (th != 0 && td > eff) eff = td;
            countStop(cnt);
            chk(th != 0 ? "R4 thermal throttle count" : "R3 throttle count", cnt, 2 * eff);
          end
    swThrEn = 1'b0; thermAlarm = 1'b0;

    // R5 halt
    swThrEn = 1'b1; swDuty = 3'd7;
    haltInd = 1'b1;
    @(negedge clk);
    chk("R5 enter C1", int'(curState), 1);
    countStop(cnt);
    chk("R5 no stop in C1", cnt, 0);
    haltInd = 1'b0;
    @(negedge clk);
    chk("R5 back to C0", int'(curState), 0);
    swThrEn = 1'b0;

    // R2 ignored codes
    doWrite(1);
    chk("R2 code 1 ignored", int'(curState), 0);
    doWrite(7);
    chk("R2 code 7 ignored", int'(curState), 0);

    // R6 C2
    doWrite(2);
    chk("R2 enter C2", int'(curState), 2);
    countStop(cnt);
    chk("R6 stop held in C2", cnt, 16);
    doWrite(0);
    chk("R2 C2 to C0", int'(curState), 0);
    chk("R6 stop released", int'(stopClkReq), 0);

    // R7..R12 sleep sequences
    for (int ti = 0; ti < 5; ti++)
      for (int di = 0; di < 4; di++) begin
        int tgt, d, sd;
        bit cfg, isS1, gated;
        case (ti)
          0, 1: tgt = 3;
          2: tgt = 4;
          3: tgt = 5;
          default: tgt = 6;
        endcase
        cfg = (ti == 1);
        case (di)
          0: sd = 0;
          1: sd = 2;
          2: sd = 3;
          default: sd = 5;
        endcase
        d = (sd < 2) ? 2 : sd;
        isS1 = (tgt == 3);
        gated = (tgt >= 4);
        sleepCpuEn = cfg;
        stepDelay = 4'(sd);
        doWrite(tgt);
        for (int k = 0; k <= 2 * d + 1; k++) begin
          chk("R7 stop during entry", int'(stopClkReq), 1);
          chk("R8 cpu sleep", int'(cpuSleepReq), (isS1 && cfg && k >= d) ? 1 : 0);
          chk("R9 clock gating", int'(clkEn), (gated && k >= 2 * d) ? 0 : ALL_ON);
          chk("R9 rtc on", int'(rtcClkEn), 1);
          chk("R9 mem retained", int'(memRetained), (tgt == 4 && k >= 2 * d) ? 1 : 0);
          chk("R12 busy", int'(busy), (k < 2 * d) ? 1 : 0);
          chk("R12 state held", int'(curState), tgt);
          if (k == 1) begin tgtState = 3'd0; tgtWrEn = 1'b1; end
          if (k == 2) tgtWrEn = 1'b0;
          @(negedge clk);
        end
        doWrite(0);
        chk("R12 write ignored in sleep", int'(curState), tgt);
        wakeEvt = 1'b1;
        @(negedge clk);
        wakeEvt = 1'b0;
        if (tgt <= 4) begin
          for (int k = 0; k <= 2 * d; k++) begin
            chk("R10 state", int'(curState), (k < 2 * d) ? tgt : 0);
            chk("R10 stop", int'(stopClkReq), (k < 2 * d) ? 1 : 0);
            chk("R10 cpu sleep", int'(cpuSleepReq), (isS1 && cfg && k < d) ? 1 : 0);
            chk("R10 clocks on", int'(clkEn), ALL_ON);
            chk("R10 mem cleared", int'(memRetained), 0);
            chk("R10 busy", int'(busy), (k < 2 * d) ? 1 : 0);
            @(negedge clk);
          end
        end else begin
          chk("R11 state", int'(curState), 0);
          chk("R11 stop", int'(stopClkReq), 0);
          chk("R11 clocks on", int'(clkEn), ALL_ON);
          chk("R11 busy", int'(busy), 0);
          chk("R11 mem", int'(memRetained), 0);
        end
      end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule